// File: doc/BRIEF.md
# Windowed Glitch Filter Bank

This block cleans up a parallel bus of asynchronous input pins before the signals reach interrupt logic or peripherals. Every pin is first brought into the sample clock domain by a two-flop synchronizer. It then passes through an optional fixed filter that suppresses very short pulses. Finally it can pass through one of a pool of flexible filter channels. Each channel can be pointed at any pin and has its own window length and threshold, both counted in sample clock cycles.

A flexible channel holds a current output level. The first sample that disagrees with that level opens an observation window of `win` samples. Inside the window the channel counts the samples that disagree with its output. When the count reaches `thr`, the output toggles and the window closes. If the window runs out first, the count is dropped and the output stays where it was. A pulse shorter than `thr` samples is therefore removed. A pulse of `thr` samples or more is passed on with its length unchanged.

The input bus is sampled on every clock and the filtered bus is produced on every clock. There is no handshake and no back-pressure. Channels are configured through a one-cycle write strobe. A channel should be disabled before it is pointed at a new pin or given new settings.

Top module: `gfb_bank`

## Requirements
- R1: With every filter disabled, each `pin_o` bit follows its `pin_i` bit exactly 2 clock cycles later, through the synchronizer alone.
- R2: After reset, all fixed filters and all flexible channels are disabled, so a 1-cycle pulse on any pin appears at `pin_o` 2 cycles later.
- R3: A channel write (`cfg_we` high at a clock edge, channel number `cfg_chan`) is rejected when `cfg_win` is 0, when `cfg_thr` is greater than `cfg_win`, or when `cfg_pin` is not less than the pin count. A rejected write leaves every stored enable, pin, window and threshold unchanged.
- R4: An enabled channel with threshold T (T of 0 behaves as 1) passes an isolated pulse of L ≥ T cycles with its length kept and T cycles of added latency. It removes a pulse of L < T cycles completely.
- R5: Disagreeing samples are counted within a window of `win` samples that opens at the first disagreeing sample, whether or not those samples are contiguous. If the window expires before the count reaches the threshold, the output is left unchanged. The output toggles only after a sample that disagrees with it.
- R6: The fixed filter of a pin, enabled by bit p of the vector written through `fix_we`/`fix_en_i`, removes pulses of 1 cycle. It passes pulses of 2 or more cycles with their length kept and 2 cycles of added latency.
- R7: When the fixed filter and a flexible channel are both enabled on one pin, the fixed filter's output feeds the channel. Their latencies add, and a pulse survives only if it passes both.
- R8: A channel feeds pin p's output when it is enabled and its `cfg_pin` equals p. When several enabled channels select the same pin, the lowest-numbered one drives it, and duplicate channels with equal settings give the same result as one. A channel never affects any other pin.
- R9: Disabling a channel through a write with `cfg_en` low returns its pin to the unfiltered path, or to the fixed filter if that is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | N_PINS | Raw asynchronous input pins |
| pin_o | output | N_PINS | Filtered pins in the sample clock domain |
| fix_we | input | 1 | Strobe that loads `fix_en_i` into the fixed-filter enables |
| fix_en_i | input | N_PINS | Fixed-filter enable, one bit per pin |
| cfg_we | input | 1 | Channel configuration write strobe |
| cfg_chan | input | CW | Channel number being written |
| cfg_en | input | 1 | Channel enable |
| cfg_pin | input | PW | Pin the channel is attached to |
| cfg_win | input | 8 | Window length in samples, 1 to 255 |
| cfg_thr | input | 8 | Disagreement count needed to toggle, at most `cfg_win` |

## Verification
Isolated single pulses are swept over their length against a range of thresholds. This separates pulses that are exactly at the threshold from pulses one cycle shorter, and also checks the latency and the kept pulse length. The same sweep on the fixed path locates the two-cycle boundary, and with both filters on one pin it shows whether the two latencies add. Pairs of short pulses with a gap between them are applied with a long window and then with a short one. This tells counting across a gap apart from a window that expires. Writes with a threshold above the window or a window of zero are followed by pulses whose outcome would differ had the write been taken. Channels stacked on one pin show which channel wins.

// File: rtl/gfb_pkg.sv
package gfb_pkg;
  localparam int CNT_W = 8;
  typedef logic [CNT_W-1:0] gfb_cnt_t;

  function automatic logic gfb_cfg_legal(gfb_cnt_t win, gfb_cnt_t thr);
    return (win != '0) && (thr <= win);
  endfunction
endpackage

// File: rtl/gfb_sync.sv
module gfb_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gfb_fixed.sv
module gfb_fixed (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic prev_q, hold_q;

  // hold_q moves only when two consecutive samples agree on a new level
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      prev_q <= d;
      if (!en) begin
        hold_q <= d;
      end else if ((d == prev_q) && (d != hold_q)) begin
        hold_q <= d;
      end
    end
  end

  assign q = en ? hold_q : d;
endmodule

// File: rtl/gfb_flex_chan.sv
module gfb_flex_chan
  import gfb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     clr,
  input  gfb_cnt_t win,
  input  gfb_cnt_t thr,
  input  logic     x,
  output logic     y
);
  logic     lvl_q;
  gfb_cnt_t wcnt_q, mcnt_q;
  logic     mism, open, active, hit, expire;
  gfb_cnt_t wnext, mnext;

  always_comb begin
    mism   = x ^ lvl_q;
    open   = (wcnt_q != '0);
    active = open | mism;
    wnext  = open ? (wcnt_q + gfb_cnt_t'(1)) : gfb_cnt_t'(1);
    mnext  = mcnt_q + {{(CNT_W-1){1'b0}}, mism};
    hit    = mism && (mnext >= thr);
    expire = (wnext >= win);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      wcnt_q <= '0;
      mcnt_q <= '0;
    end else if (!en || clr) begin
      lvl_q  <= x;
      wcnt_q <= '0;
      mcnt_q <= '0;
    end else if (active) begin
      if (hit) begin
        lvl_q  <= ~lvl_q;
        wcnt_q <= '0;
        mcnt_q <= '0;
      end else if (expire) begin
        wcnt_q <= '0;
        mcnt_q <= '0;
      end else begin
        wcnt_q <= wnext;
        mcnt_q <= mnext;
      end
    end
  end

  assign y = lvl_q;
endmodule

// File: rtl/gfb_bank.sv
module gfb_bank
  import gfb_pkg::*;
#(
  parameter  int N_PINS = 8,
  parameter  int N_CHAN = 8,
  localparam int PW = (N_PINS > 1) ? $clog2(N_PINS) : 1,
  localparam int CW = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  input  logic              fix_we,
  input  logic [N_PINS-1:0] fix_en_i,
  input  logic              cfg_we,
  input  logic [CW-1:0]     cfg_chan,
  input  logic              cfg_en,
  input  logic [PW-1:0]     cfg_pin,
  input  logic [CNT_W-1:0]  cfg_win,
  input  logic [CNT_W-1:0]  cfg_thr
);
  logic [N_PINS-1:0]          sync_v, fix_o, fix_en_q;
  logic [N_CHAN-1:0]          en_q, chan_in, chan_out, chan_clr;
  logic [N_CHAN-1:0][PW-1:0]  pin_q;
  gfb_cnt_t [N_CHAN-1:0]      win_q, thr_q;
  logic                       cfg_ok;

  gfb_sync #(.W(N_PINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(sync_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      fix_en_q <= '0;
    else if (fix_we) fix_en_q <= fix_en_i;
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_fix
    gfb_fixed fix_i (
      .clk(clk), .rst_n(rst_n), .en(fix_en_q[p]), .d(sync_v[p]), .q(fix_o[p])
    );
  end

  assign cfg_ok = cfg_we && gfb_cfg_legal(cfg_win, cfg_thr)
                  && (int'(cfg_pin) < N_PINS) && (int'(cfg_chan) < N_CHAN);

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    assign chan_clr[c] = cfg_ok && (cfg_chan == CW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[c]  <= 1'b0;
        pin_q[c] <= '0;
        win_q[c] <= gfb_cnt_t'(1);
        thr_q[c] <= gfb_cnt_t'(1);
      end else if (chan_clr[c]) begin
        en_q[c]  <= cfg_en;
        pin_q[c] <= cfg_pin;
        win_q[c] <= cfg_win;
        thr_q[c] <= cfg_thr;
      end
    end

    assign chan_in[c] = fix_o[pin_q[c]];

    gfb_flex_chan chan_i (
      .clk(clk), .rst_n(rst_n), .en(en_q[c]), .clr(chan_clr[c]),
      .win(win_q[c]), .thr(thr_q[c]), .x(chan_in[c]), .y(chan_out[c])
    );
  end

  // lowest-numbered enabled channel on a pin wins: scan downward, last match sticks
  for (genvar p = 0; p < N_PINS; p++) begin : g_out
    logic sel;
    always_comb begin
      sel = fix_o[p];
      for (int c = N_CHAN - 1; c >= 0; c--) begin
        if (en_q[c] && (pin_q[c] == PW'(p))) sel = chan_out[c];
      end
    end
    assign pin_o[p] = sel;
  end
endmodule

// File: rtl/gfb_bank_chk.sv
module gfb_bank_chk
  import gfb_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int N_CHAN = 8,
  parameter int PW = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_we,
  input logic [CNT_W-1:0]          cfg_win,
  input logic [CNT_W-1:0]          cfg_thr,
  input logic [N_CHAN-1:0]         en_q,
  input logic [N_CHAN-1:0][PW-1:0] pin_q,
  input gfb_cnt_t [N_CHAN-1:0]     win_q,
  input gfb_cnt_t [N_CHAN-1:0]     thr_q,
  input logic [N_PINS-1:0]         fix_en_q,
  input logic [N_PINS-1:0]         sync_v,
  input logic [N_PINS-1:0]         fix_o,
  input logic [N_CHAN-1:0]         chan_in,
  input logic [N_CHAN-1:0]         chan_out
);
  // R3: an illegal write leaves all stored channel settings untouched
  a_r3_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && ((cfg_win == '0) || (cfg_thr > cfg_win)))
    |=> ($stable(en_q) && $stable(pin_q) && $stable(win_q) && $stable(thr_q)));

  for (genvar c = 0; c < N_CHAN; c++) begin : g_c
    // R3: an enabled channel always holds a legal window/threshold pair
    a_r3_cfg_legal: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[c] |-> ((win_q[c] != '0) && (thr_q[c] <= win_q[c])));
    // R5: a channel output toggles only after a sample that disagreed with it
    a_r5_flip_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[c] && $past(en_q[c]) && (chan_out[c] != $past(chan_out[c])))
      |-> ($past(chan_in[c]) != $past(chan_out[c])));
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_p
    // R6: a fixed-filter transition needs two agreeing samples at the new level
    a_r6_fixed_two: assert property (@(posedge clk) disable iff (!rst_n)
      (fix_en_q[p] && $past(fix_en_q[p]) && $past(fix_en_q[p], 2)
       && (fix_o[p] != $past(fix_o[p])))
      |-> (($past(sync_v[p]) == fix_o[p]) && ($past(sync_v[p], 2) == fix_o[p])));
  end
endmodule

bind gfb_bank gfb_bank_chk #(.N_PINS(N_PINS), .N_CHAN(N_CHAN), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_thr(cfg_thr),
  .en_q(en_q), .pin_q(pin_q), .win_q(win_q), .thr_q(thr_q), .fix_en_q(fix_en_q),
  .sync_v(sync_v), .fix_o(fix_o), .chan_in(chan_in), .chan_out(chan_out)
);

// File: tb/gfb_bank_tb_top.sv
`timescale 1ns/1ps
module gfb_bank_tb_top;
  localparam int NP = 8;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_o;
  logic          fix_we = 1'b0;
  logic [NP-1:0] fix_en_i = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_chan = '0;
  logic          cfg_en = 1'b0;
  logic [2:0]    cfg_pin = '0;
  logic [7:0]    cfg_win = 8'd1;
  logic [7:0]    cfg_thr = 8'd1;

  int nvec = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  gfb_bank #(.N_PINS(NP), .N_CHAN(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_o(pin_o),
    .fix_we(fix_we), .fix_en_i(fix_en_i),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_en(cfg_en),
    .cfg_pin(cfg_pin), .cfg_win(cfg_win), .cfg_thr(cfg_thr)
  );

  task automatic wr_chan(input int ch, input bit en, input int pin, input int win, input int thr);
    @(negedge clk);
    cfg_chan = 3'(ch); cfg_en = en; cfg_pin = 3'(pin);
    cfg_win = 8'(win); cfg_thr = 8'(thr); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_fix(input logic [NP-1:0] mask);
    @(negedge clk);
    fix_en_i = mask; fix_we = 1'b1;
    @(negedge clk);
    fix_we = 1'b0;
  endtask

  // drive pattern bits on one pin, one per cycle, sampling the output at each negedge
  task automatic run_pat(input int p, input logic [63:0] pat, input int plen,
                         input int ncyc, output int first, output int cnt);
    first = -1; cnt = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (pin_o[p]) begin
        if (first < 0) first = k;
        cnt++;
      end
      pin_i[p] = (k < plen) ? pat[k] : 1'b0;
    end
  endtask

  task automatic check_pulse(input string tag, input int p, input int len,
                             input bit pass, input int delay);
    int first, cnt, ef, ec;
    logic [63:0] pat;
    pat = (64'd1 << len) - 64'd1;
    run_pat(p, pat, len, delay + len + 40, first, cnt);
    ef = pass ? delay : -1;
    ec = pass ? len : 0;
    nvec++;
    if (first != ef || cnt != ec) begin
      nfail++;
      $display("FAIL %s pin%0d len%0d: actual first=%0d high=%0d expected first=%0d high=%0d",
               tag, p, len, first, cnt, ef, ec);
    end
  endtask

  task automatic check_seen(input string tag, input int p, input logic [63:0] pat,
                            input int plen, input bit exp_high);
    int first, cnt;
    run_pat(p, pat, plen, plen + 60, first, cnt);
    nvec++;
    if ((cnt > 0) != exp_high) begin
      nfail++;
      $display("FAIL %s pin%0d: actual seen_high=%0d expected seen_high=%0d",
               tag, p, (cnt > 0), exp_high);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: reset state, every pin is a bare synchronizer
    for (int p = 0; p < NP; p++) check_pulse("R2", p, 1, 1'b1, 2);
    // R1: longer pulse through the unfiltered path
    check_pulse("R1", 5, 3, 1'b1, 2);

    // R6: fixed filter boundary on pin 0
    wr_fix(8'b0000_0001);
    for (int len = 1; len <= 4; len++) check_pulse("R6", 0, len, len >= 2, 4);
    wr_fix(8'b0000_0000);

    // R4: threshold sweep on channel 3 attached to pin 6, window 8
    for (int t = 1; t <= 6; t++) begin
      wr_chan(3, 1'b0, 6, 8, t);
      wr_chan(3, 1'b1, 6, 8, t);
      for (int len = 1; len <= 8; len++) check_pulse("R4", 6, len, len >= t, 2 + t);
    end

    // R7: fixed filter cascaded ahead of the channel
    wr_fix(8'b0100_0000);
    wr_chan(3, 1'b0, 6, 8, 3);
    wr_chan(3, 1'b1, 6, 8, 3);
    for (int len = 1; len <= 5; len++) check_pulse("R7", 6, len, len >= 3, 7);
    wr_chan(3, 1'b0, 6, 8, 1);
    wr_chan(3, 1'b1, 6, 8, 1);
    check_pulse("R7", 6, 1, 1'b0, 5);
    check_pulse("R7", 6, 2, 1'b1, 5);
    wr_fix(8'b0000_0000);

    // R5: pulses 11,000,11 -> four disagreements spread over seven samples
    wr_chan(3, 1'b0, 6, 10, 4);
    wr_chan(3, 1'b1, 6, 10, 4);
    check_seen("R5", 6, 64'h63, 7, 1'b1);
    wr_chan(3, 1'b0, 6, 5, 4);
    wr_chan(3, 1'b1, 6, 5, 4);
    check_seen("R5", 6, 64'h63, 7, 1'b0);
    // R5: 1,1,0,1 in a 4-sample window with threshold 3 toggles; 1,0,1 in 3 does not
    wr_chan(3, 1'b0, 6, 4, 3);
    wr_chan(3, 1'b1, 6, 4, 3);
    check_seen("R5", 6, 64'hB, 4, 1'b1);
    wr_chan(3, 1'b0, 6, 3, 3);
    wr_chan(3, 1'b1, 6, 3, 3);
    check_seen("R5", 6, 64'h5, 3, 1'b0);
    wr_chan(3, 1'b0, 6, 3, 3);

    // R3: legal setup, then illegal writes must not change behaviour
    wr_chan(0, 1'b1, 1, 8, 3);
    check_pulse("R3", 1, 3, 1'b1, 5);
    wr_chan(0, 1'b1, 1, 8, 9);
    check_pulse("R3", 1, 2, 1'b0, 5);
    check_pulse("R3", 1, 3, 1'b1, 5);
    wr_chan(0, 1'b1, 1, 0, 0);
    check_pulse("R3", 1, 2, 1'b0, 5);
    check_pulse("R3", 1, 3, 1'b1, 5);
    wr_chan(0, 1'b0, 1, 8, 3);

    // R8: two channels on pin 3, lowest number wins
    wr_chan(0, 1'b1, 3, 8, 2);
    wr_chan(1, 1'b1, 3, 8, 5);
    check_pulse("R8", 3, 3, 1'b1, 4);
    check_pulse("R8", 3, 1, 1'b0, 4);
    check_pulse("R8", 4, 1, 1'b1, 2);
    wr_chan(0, 1'b0, 3, 8, 2);
    check_pulse("R8", 3, 3, 1'b0, 7);
    check_pulse("R8", 3, 5, 1'b1, 7);
    wr_chan(2, 1'b1, 3, 8, 5);
    check_pulse("R8", 3, 5, 1'b1, 7);
    check_pulse("R8", 3, 4, 1'b0, 7);

    // R9: disabling returns the pin to the bare path
    wr_chan(1, 1'b0, 3, 8, 5);
    wr_chan(2, 1'b0, 3, 8, 5);
    check_pulse("R9", 3, 1, 1'b1, 2);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule